// File: doc/BRIEF.md
# RTC Alarm Flag and Interrupt Controller

This block keeps the sticky event flags of a real-time clock and turns them into two active-low interrupt lines. Two alarm comparators each deliver a one-cycle match pulse, the oscillator supervisor delivers a level that says the oscillator has halted, and the oscillator-disable control bit arrives as a level. Each event sets its own flag. A flag stays set until software clears it.

Software reaches the block through a byte-wide register port. One status register holds the three flags. One control register holds the two alarm interrupt enables and the bit that routes alarm 2. Software may only clear flags. A write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the set wins.

Alarm 1 can only interrupt on the primary line. Alarm 2 goes to the primary line or to the secondary line, as the routing bit selects.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Out of reset the status register (address 0Fh) reads 80h, the control register (address 0Eh) reads 04h, and both `inta_no` and `intb_no` are high.
- R2: A one-cycle `alm1_hit_i` pulse sets the alarm 1 flag, status bit 0, on the next clock edge. The flag stays at 1 over later cycles.
- R3: A one-cycle `alm2_hit_i` pulse sets the alarm 2 flag, status bit 1, on the next clock edge. The flag stays at 1 over later cycles.
- R4: A status write with 0 in a flag bit clears that flag. A 1 in a flag bit leaves the flag as it was, so software can never set a flag.
- R5: The oscillator-stop flag, status bit 7, is 1 after reset. It is set in every cycle where `osc_halt_i` or `osc_off_i` is high, and it stays at 1 until software writes 0 to it.
- R6: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends at 1.
- R7: Unused bits always read 0: status bits 6 to 2 and control bits 7 to 3. In the control register, bit 0 is the alarm 1 enable, bit 1 is the alarm 2 enable and bit 2 is the alarm 2 routing bit. All three read back as written.
- R8: `inta_no` is low whenever either of these holds: the alarm 1 flag and its enable are both 1, or the alarm 2 flag and its enable are both 1 with the routing bit at 0.
- R9: `intb_no` is low exactly when the alarm 2 flag and its enable are both 1 and the routing bit is 1.
- R10: While an enable bit is 0, its flag has no effect on either interrupt output.
- R11: A write to any address other than 0Eh or 0Fh changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| alm1_hit_i | input | 1 | Alarm 1 match pulse |
| alm2_hit_i | input | 1 | Alarm 2 match pulse |
| osc_halt_i | input | 1 | Oscillator has stopped (level) |
| osc_off_i | input | 1 | Oscillator disabled by control (level) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| inta_no | output | 1 | Primary interrupt, active low |
| intb_no | output | 1 | Secondary interrupt, active low |

## Verification
The hardest case to reach is a hardware set that lands in the same clock edge as a software clear of the same flag. From the ports this is only visible as a flag that survives its own clear. The bench raises the alarm pulse and the zero-write strobe in the same cycle, then reads back status. It also holds the oscillator-disable level high across a clear and checks that the stop flag stays set. Routing is checked by flipping the routing bit while alarm 2 is pending and watching the interrupt move from one line to the other.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned FL_A1  = 0;
  localparam int unsigned FL_A2  = 1;
  localparam int unsigned FL_OSF = 2;

  localparam int unsigned CB_A1IE  = 0;
  localparam int unsigned CB_A2IE  = 1;
  localparam int unsigned CB_INTCN = 2;
  localparam int unsigned CTRL_W   = 3;

  typedef struct packed {
    logic route_b;
    logic a2_en;
    logic a1_en;
  } ctrl_t;

  // status bit position of each flag
  function automatic int unsigned flag_pos(int unsigned idx);
    case (idx)
      FL_A1:   return 0;
      FL_A2:   return 1;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route (
  input  logic a1_act_i,
  input  logic a2_act_i,
  input  logic route_b_i,
  output logic inta_no,
  output logic intb_no
);
  assign inta_no = ~(a1_act_i | (a2_act_i & ~route_b_i));
  assign intb_no = ~(a2_act_i & route_b_i);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0F,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alm1_hit_i,
  input  logic              alm2_hit_i,
  input  logic              osc_halt_i,
  input  logic              osc_off_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              inta_no,
  output logic              intb_no
);
  logic             stat_wr, ctrl_wr;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  ctrl_t            ctrl_q;

  assign stat_wr = reg_wr_i && (reg_addr_i == STAT_ADDR);
  assign ctrl_wr = reg_wr_i && (reg_addr_i == CTRL_ADDR);

  assign flag_set[FL_A1]  = alm1_hit_i;
  assign flag_set[FL_A2]  = alm2_hit_i;
  assign flag_set[FL_OSF] = osc_halt_i | osc_off_i;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam int unsigned POS = flag_pos(g);
    assign flag_clr[g] = stat_wr & ~reg_wdata_i[POS];
    rtc_sticky_flag #(.RST_VAL(g == FL_OSF)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '{route_b: 1'b1, a2_en: 1'b0, a1_en: 1'b0};
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == STAT_ADDR) begin
      for (int unsigned i = 0; i < NFLAG; i++) reg_rdata_o[flag_pos(i)] = flag_q[i];
    end else if (reg_addr_i == CTRL_ADDR) begin
      reg_rdata_o[CTRL_W-1:0] = ctrl_q;
    end
  end

  rtc_irq_route u_route (
    .a1_act_i  (flag_q[FL_A1] & ctrl_q.a1_en),
    .a2_act_i  (flag_q[FL_A2] & ctrl_q.a2_en),
    .route_b_i (ctrl_q.route_b),
    .inta_no   (inta_no),
    .intb_no   (intb_no)
  );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       alm1_hit_i,
  input logic       alm2_hit_i,
  input logic       osc_halt_i,
  input logic       osc_off_i,
  input logic [2:0] flag_q,
  input logic [2:0] ctrl_q,
  input logic       inta_no,
  input logic       intb_no
);
  p_a1_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm1_hit_i |=> flag_q[0]);
  p_a2_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm2_hit_i |=> flag_q[1]);
  p_no_sw_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alm1_hit_i && !flag_q[0]) |=> !flag_q[0]);
  p_osf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_halt_i || osc_off_i) |=> flag_q[2]);
  p_inta_a1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && ctrl_q[0]) |-> !inta_no);
  p_intb_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intb_no |-> (flag_q[1] && ctrl_q[1] && ctrl_q[2]));
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[0] && !ctrl_q[1]) |-> (inta_no && intb_no));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alm1_hit_i (alm1_hit_i),
  .alm2_hit_i (alm2_hit_i),
  .osc_halt_i (osc_halt_i),
  .osc_off_i  (osc_off_i),
  .flag_q     (flag_q),
  .ctrl_q     (ctrl_q),
  .inta_no    (inta_no),
  .intb_no    (intb_no)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT = 8'h0F;
  localparam logic [7:0] CTRL = 8'h0E;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alm1_hit_i = 1'b0, alm2_hit_i = 1'b0;
  logic       osc_halt_i = 1'b0, osc_off_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00, reg_wdata_i = 8'h00, reg_rdata_o;
  logic       inta_no, intb_no;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_alarm_irq dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic pins(string req, logic a, logic b);
    check({req, " inta"}, {7'd0, inta_no}, {7'd0, a});
    check({req, " intb"}, {7'd0, intb_no}, {7'd0, b});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(STAT, d); check("R1 status", d, 8'h80);
    rd(CTRL, d); check("R1 ctrl", d, 8'h04);
    pins("R1", 1'b1, 1'b1);
  endtask

  task automatic t_alarm1();
    logic [7:0] d;
    wr(STAT, 8'h00);
    rd(STAT, d); check("R5 osf clear", d, 8'h00);
    alm1_hit_i = 1'b1; step(); alm1_hit_i = 1'b0;
    rd(STAT, d); check("R2 a1 set", d, 8'h01);
    step(); step();
    rd(STAT, d); check("R2 a1 sticky", d, 8'h01);
    pins("R10 a1 disabled", 1'b1, 1'b1);
    wr(CTRL, 8'h05);
    pins("R8 a1 enabled", 1'b0, 1'b1);
    wr(STAT, 8'hFF);
    rd(STAT, d); check("R4 write one keeps", d, 8'h01);
    wr(STAT, 8'h00);
    rd(STAT, d); check("R4 write zero clears", d, 8'h00);
    pins("R8 a1 cleared", 1'b1, 1'b1);
  endtask

  task automatic t_alarm2_route();
    logic [7:0] d;
    wr(CTRL, 8'h00);
    alm2_hit_i = 1'b1; step(); alm2_hit_i = 1'b0;
    rd(STAT, d); check("R3 a2 set", d, 8'h02);
    pins("R10 a2 disabled", 1'b1, 1'b1);
    wr(CTRL, 8'h02);
    pins("R8 a2 to inta", 1'b0, 1'b1);
    wr(CTRL, 8'h06);
    pins("R9 a2 to intb", 1'b1, 1'b0);
    step();
    rd(STAT, d); check("R3 a2 sticky", d, 8'h02);
    alm1_hit_i = 1'b1; step(); alm1_hit_i = 1'b0;
    wr(CTRL, 8'h07);
    pins("R8 R9 both", 1'b0, 1'b0);
    wr(STAT, 8'hFE);
    rd(STAT, d); check("R4 selective clear", d, 8'h02);
    wr(STAT, 8'h00);
    pins("R9 cleared", 1'b1, 1'b1);
  endtask

  task automatic t_osf();
    logic [7:0] d;
    osc_halt_i = 1'b1; step(); osc_halt_i = 1'b0;
    rd(STAT, d); check("R5 halt sets", d, 8'h80);
    step();
    rd(STAT, d); check("R5 sticky", d, 8'h80);
    wr(STAT, 8'h7F);
    rd(STAT, d); check("R4 osf clear", d, 8'h00);
    osc_off_i = 1'b1; step();
    wr(STAT, 8'h00);
    rd(STAT, d); check("R6 osf held by disable", d, 8'h80);
    osc_off_i = 1'b0;
    wr(STAT, 8'h00);
    rd(STAT, d); check("R5 osf cleared", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    reg_addr_i = STAT; reg_wdata_i = 8'h00; reg_wr_i = 1'b1;
    alm1_hit_i = 1'b1; alm2_hit_i = 1'b1;
    step();
    reg_wr_i = 1'b0; alm1_hit_i = 1'b0; alm2_hit_i = 1'b0;
    rd(STAT, d); check("R6 set wins", d, 8'h03);
  endtask

  task automatic t_misc();
    logic [7:0] d;
    wr(8'h10, 8'h00);
    rd(STAT, d); check("R11 stray write status", d, 8'h03);
    wr(8'h0D, 8'h00);
    rd(CTRL, d); check("R11 stray write ctrl", d, 8'h07);
    wr(CTRL, 8'hFA);
    rd(CTRL, d); check("R7 ctrl upper zero", d, 8'h02);
    wr(STAT, 8'hFF);
    rd(STAT, d); check("R7 status unused zero", d, 8'h03);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_alarm1();
    t_alarm2_route();
    t_osf();
    t_collide();
    t_misc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule